// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Release Timer

This block watches a flash interface while it runs memory-mapped prefetch reads. When the prefetch buffer fills and nobody drains it, the controller would otherwise keep chip select asserted for as long as the stall lasts. The timer counts the cycles in which the buffer is full, the timeout is enabled and no consumer read takes place. When that count reaches a programmable period, it sends a one-cycle release request to the sequencer. The sequencer then ends the burst and deasserts chip select, and the flash can drop into standby.

The same event sets a sticky timeout flag, which software clears through a write-one-to-clear input. The flag drives an interrupt line through an enable. If the timeout is disabled, no release request is made, and chip select stays asserted for the whole stall. The prefetch buffer and the bus slave sit outside this block.

A cycle is called *qualifying* when `tmo_en_i` = 1, `fifo_full_i` = 1 and `rd_strobe_i` = 0. A *run* is an unbroken sequence of qualifying cycles.

Top module: `mm_cs_release_timer`

## Requirements
- R1: For a period P in 0..65535, `release_o` goes high in the clock cycle after the (P+1)-th consecutive qualifying cycle of a run.
- R2: `release_o` is high for exactly one cycle, and it does not pulse again during the same run.
- R3: A cycle with `fifo_full_i` = 0 ends the run, and the count starts again from zero.
- R4: A cycle with `rd_strobe_i` = 1 ends the run, and the count starts again from zero.
- R5: With `tmo_en_i` = 0, `release_o` never pulses and `tmo_flag_o` never sets, however long the buffer stays full.
- R6: With P = 0, `release_o` pulses in the cycle after the first qualifying cycle.
- R7: `tmo_flag_o` becomes 1 in the same cycle as the release pulse, and it stays 1 until it is cleared.
- R8: `flag_clr_i` = 1 clears `tmo_flag_o` in the next cycle. If an expiry happens in the same cycle, setting the flag wins.
- R9: `irq_o` is 1 exactly when `tmo_flag_o` = 1 and `irq_en_i` = 1.
- R10: After reset, `release_o`, `tmo_flag_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_full_i | input | 1 | Prefetch buffer is full |
| rd_strobe_i | input | 1 | A consumer read of the buffer takes place this cycle |
| tmo_en_i | input | 1 | Enables the timeout counter |
| tmo_period_i | input | PERIOD_W (16) | Timeout period in cycles |
| irq_en_i | input | 1 | Enables the interrupt from the flag |
| flag_clr_i | input | 1 | Write-one-to-clear for the timeout flag |
| release_o | output | 1 | One-cycle request to release chip select |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The assertions assume that `tmo_period_i` holds steady for the whole of a run. The timing check compares the release cycle against the period as it was sampled in that cycle, and a period lowered mid-run would break that check. The stimulus changes the period only while the buffer is not full or while the timeout is disabled. Every other input changes freely, once per cycle, away from the clock edge.

// File: rtl/mmto_pkg.sv
package mmto_pkg;
  localparam int unsigned PERIOD_W_DEF = 16;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

  function automatic flag_op_e flag_op(input logic set_req, input logic clr_req);
    if (set_req)      return FLAG_SET;
    else if (clr_req) return FLAG_CLEAR;
    else              return FLAG_HOLD;
  endfunction
endpackage

// File: rtl/mmto_idle_counter.sv
module mmto_idle_counter #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                qualify_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                hit_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                fired_q, fired_d;
  logic                cnt_en, fired_en;
  logic                at_limit;

  assign at_limit = (cnt_q == period_i);

  always_comb begin
    hit_o   = qualify_i & ~fired_q & at_limit;
    cnt_d   = cnt_q;
    fired_d = fired_q;
    if (!qualify_i) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else if (hit_o) begin
      fired_d = 1'b1;
    end else if (!fired_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en   = (cnt_d != cnt_q);
  assign fired_en = (fired_d != fired_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
    end else if (fired_en) begin
      fired_q <= fired_d;
    end
  end
endmodule

// File: rtl/mmto_sticky_flag.sv
module mmto_sticky_flag
  import mmto_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic     flag_q, flag_d, flag_en;
  flag_op_e op;

  always_comb begin
    op     = flag_op(set_i, clr_i);
    flag_d = flag_q;
    case (op)
      FLAG_SET:   flag_d = 1'b1;
      FLAG_CLEAR: flag_d = 1'b0;
      default:    flag_d = flag_q;
    endcase
  end

  assign flag_en = (flag_d != flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mm_cs_release_timer.sv
module mm_cs_release_timer #(
  parameter int unsigned PERIOD_W = mmto_pkg::PERIOD_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fifo_full_i,
  input  logic                rd_strobe_i,
  input  logic                tmo_en_i,
  input  logic [PERIOD_W-1:0] tmo_period_i,
  input  logic                irq_en_i,
  input  logic                flag_clr_i,
  output logic                release_o,
  output logic                tmo_flag_o,
  output logic                irq_o
);
  logic qualify;
  logic hit;
  logic rel_q, rel_d, rel_en;

  assign qualify = tmo_en_i & fifo_full_i & ~rd_strobe_i;

  mmto_idle_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .qualify_i (qualify),
    .period_i  (tmo_period_i),
    .hit_o     (hit)
  );

  mmto_sticky_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit),
    .clr_i  (flag_clr_i),
    .flag_o (tmo_flag_o)
  );

  always_comb begin
    rel_d  = hit;
    rel_en = (rel_d != rel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
    end else if (rel_en) begin
      rel_q <= rel_d;
    end
  end

  assign release_o = rel_q;
  assign irq_o     = tmo_flag_o & irq_en_i;
endmodule

// File: rtl/mm_cs_release_timer_chk.sv
module mm_cs_release_timer_chk #(
  parameter int unsigned PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fifo_full_i,
  input logic                rd_strobe_i,
  input logic                tmo_en_i,
  input logic [PERIOD_W-1:0] tmo_period_i,
  input logic                irq_en_i,
  input logic                flag_clr_i,
  input logic                release_o,
  input logic                tmo_flag_o,
  input logic                irq_o
);
  logic          qual;
  logic [PERIOD_W:0] run_q;

  assign qual = tmo_en_i & fifo_full_i & ~rd_strobe_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!qual) begin
      run_q <= '0;
    end else if (run_q != {(PERIOD_W+1){1'b1}}) begin
      run_q <= run_q + 1'b1;
    end
  end

  // R1 R6: the release comes after exactly period earlier qualifying cycles
  assert_release_timing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> ($past(run_q) == {1'b0, $past(tmo_period_i)}));

  // R2
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);

  // R3 R4 R5: a release needs a qualifying cycle just before it
  assert_needs_qualify_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> $past(qual));

  // R7
  assert_flag_with_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> tmo_flag_o);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag_o && !flag_clr_i) |=> tmo_flag_o);

  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag_o) |-> release_o);

  // R8
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !qual) |=> !tmo_flag_o);

  // R9
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (tmo_flag_o && irq_en_i));
endmodule

bind mm_cs_release_timer mm_cs_release_timer_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_full_i  (fifo_full_i),
  .rd_strobe_i  (rd_strobe_i),
  .tmo_en_i     (tmo_en_i),
  .tmo_period_i (tmo_period_i),
  .irq_en_i     (irq_en_i),
  .flag_clr_i   (flag_clr_i),
  .release_o    (release_o),
  .tmo_flag_o   (tmo_flag_o),
  .irq_o        (irq_o)
);

// File: tb/sim_mm_cs_release_timer.sv
module sim_mm_cs_release_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_full = 1'b0, rd_strobe = 1'b0, tmo_en = 1'b0;
  logic [PW-1:0] period = '0;
  logic          irq_en = 1'b0, flag_clr = 1'b0;
  logic          rel, flag, irq;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R10";

  // reference model state
  int unsigned m_idle = 0;
  bit          m_done = 1'b0;
  bit          m_rel = 1'b0;
  bit          m_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_cs_release_timer #(.PERIOD_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_full_i(fifo_full), .rd_strobe_i(rd_strobe),
    .tmo_en_i(tmo_en), .tmo_period_i(period), .irq_en_i(irq_en),
    .flag_clr_i(flag_clr), .release_o(rel), .tmo_flag_o(flag), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle <= 0; m_done <= 1'b0; m_rel <= 1'b0; m_flag <= 1'b0;
    end else begin
      bit q, fire;
      q    = tmo_en && fifo_full && !rd_strobe;
      fire = q && !m_done && (m_idle == int'(period));
      m_rel <= fire;
      if (!q) begin
        m_idle <= 0; m_done <= 1'b0;
      end else if (fire) begin
        m_done <= 1'b1;
      end else if (!m_done) begin
        m_idle <= m_idle + 1;
      end
      if (fire) m_flag <= 1'b1;
      else if (flag_clr) m_flag <= 1'b0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock, then compare outputs with the model away from the edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check({cur_req, " release"}, rel, m_rel);
    check({cur_req, " flag"}, flag, m_flag);
    check({cur_req, " irq"}, irq, m_flag && irq_en);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic idle_out();
    fifo_full = 1'b0; rd_strobe = 1'b0; flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit any;
    @(negedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 release", rel, 1'b0);
    check("R10 flag", flag, 1'b0);
    check("R10 irq", irq, 1'b0);
    rst_n = 1'b1;
    step();

    // R1 R2 R7 R9: period 3
    cur_req = "R1";
    tmo_en = 1'b1; period = 16'd3; fifo_full = 1'b1;
    steps(3);
    check("R1 before expiry", rel, 1'b0);
    step();
    check("R1 release at P+1", rel, 1'b1);
    check("R7 flag with release", flag, 1'b1);
    check("R9 irq masked", irq, 1'b0);
    cur_req = "R2";
    step();
    check("R2 pulse ends", rel, 1'b0);
    any = 1'b0;
    for (int i = 0; i < 10; i++) begin step(); any |= rel; end
    check("R2 no second pulse", any, 1'b0);
    check("R7 flag sticky", flag, 1'b1);
    cur_req = "R9";
    irq_en = 1'b1;
    step();
    check("R9 irq enabled", irq, 1'b1);
    cur_req = "R8";
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    check("R8 flag cleared", flag, 1'b0);
    check("R9 irq follows flag", irq, 1'b0);
    idle_out();

    // R3: full drops mid-run
    cur_req = "R3";
    period = 16'd5; fifo_full = 1'b1;
    steps(4);
    fifo_full = 1'b0; step();
    fifo_full = 1'b1;
    steps(5);
    check("R3 restart no early release", rel, 1'b0);
    step();
    check("R3 release after fresh run", rel, 1'b1);
    idle_out();

    // R4: consumer read mid-run
    cur_req = "R4";
    period = 16'd2; fifo_full = 1'b1;
    steps(2);
    rd_strobe = 1'b1; step();
    rd_strobe = 1'b0;
    steps(2);
    check("R4 restart no early release", rel, 1'b0);
    step();
    check("R4 release after fresh run", rel, 1'b1);
    idle_out();

    // R5: disabled
    cur_req = "R5";
    tmo_en = 1'b0; period = 16'd0; fifo_full = 1'b1;
    any = 1'b0;
    for (int i = 0; i < 100; i++) begin step(); any |= rel; end
    check("R5 no release when disabled", any, 1'b0);
    check("R5 no flag when disabled", flag, 1'b0);
    idle_out();

    // R6: period zero
    cur_req = "R6";
    tmo_en = 1'b1; period = 16'd0; fifo_full = 1'b1;
    step();
    check("R6 release on first cycle", rel, 1'b1);
    idle_out();

    // R8: set wins over simultaneous clear
    cur_req = "R8";
    fifo_full = 1'b1; flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    check("R8 set wins release", rel, 1'b1);
    check("R8 set wins flag", flag, 1'b1);
    idle_out();

    // R1: maximum period
    cur_req = "R1";
    period = 16'hFFFF; fifo_full = 1'b1;
    steps(65535);
    check("R1 max period before expiry", rel, 1'b0);
    step();
    check("R1 max period release", rel, 1'b1);
    idle_out();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule